// File: doc/BRIEF.md
# Operand Byte Parser for 16-bit ModRM Instructions

This block sits behind an opcode decoder in a byte-serial front end. Once the opcode is known, the decoder presents a one-cycle configuration request. The request says whether a ModRM byte follows and which kind of immediate ends the instruction. The parser then accepts operand bytes one at a time through a valid/ready handshake. It decides from the ModRM byte how many displacement bytes to take, collects those bytes, and then collects the immediate bytes.

When the last byte of the instruction has been accepted, the parser raises `done` for exactly one cycle. While `done` is high, `rec` holds the packed result. After that pulse the parser returns to idle and can accept the next configuration request. Decoding opcodes, handling prefixes and computing effective addresses are all left to other blocks.

Top module: `modrm_operand_parser`

## Requirements
- R1: After reset the parser is idle: `op_ready`=1, `in_ready`=0, `done`=0.
- R2: The ModRM byte is split into `rec[39:38]` (bits 7:6, mode), `rec[37:35]` (bits 5:3, reg) and `rec[34:32]` (bits 2:0, r/m).
- R3: With mode 00 and r/m other than 110, no displacement byte is taken and `rec[31:16]` is 0.
- R4: With mode 00 and r/m 110, two displacement bytes are taken, low byte first, and they form a direct 16-bit address in `rec[31:16]`.
- R5: With mode 01, one displacement byte is taken and sign-extended to 16 bits.
- R6: With mode 10, two displacement bytes are taken, low byte first.
- R7: With mode 11, no displacement byte is taken and `rec[31:16]` is 0.
- R8: Displacement bytes are taken directly after the ModRM byte and before any immediate byte.
- R9: `imm_kind` codes: 0 means no immediate (`rec[15:0]`=0); 1 means one byte, zero-extended; 2 means two bytes, low first; 3 means one byte, sign-extended by copying bit 7 into the upper byte.
- R10: With `has_modrm`=0, mode, reg, r/m and displacement read 0 and the first operand byte is the immediate. If there is also no immediate, `done` rises in the cycle after the request is accepted.
- R11: `done` is high for exactly the one cycle after the last byte is accepted, never before it. `in_ready` is 0 during that cycle, and `op_ready` is 1 in the cycle after it.
- R12: `in_ready` is 0 while idle, and a byte offered while idle is ignored.
- R13: Asserting reset in the middle of an instruction returns the parser to idle, and the next instruction parses correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Configuration request for a new instruction |
| has_modrm | input | 1 | A ModRM byte follows (sampled with op_valid) |
| imm_kind | input | 2 | Immediate kind, coded as in R9 (sampled with op_valid) |
| op_ready | output | 1 | Parser idle, request accepted |
| in_valid | input | 1 | Operand byte offered |
| in_data | input | 8 | Operand byte |
| in_ready | output | 1 | Parser takes a byte this cycle |
| done | output | 1 | One-cycle result strobe |
| rec | output | 40 | {mode, reg, r/m, disp[15:0], imm[15:0]} |

## Verification
A wrong byte count shows at the ports within one byte time. If the count is too low, `done` rises while the bench is still offering bytes. If it is too high, `in_ready` stays high after the last byte and `done` never arrives. A wrong routing or sign-fill decision shows in the `rec` field concerned, in the same `done` cycle. State that survives a reset shows up as a corrupted record on the first instruction after reset.

// File: rtl/modrm_pkg.sv
package modrm_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MOD_W  = 2;
  localparam int FLD_W  = 3;
  localparam int REC_W  = MOD_W + 2 * FLD_W + 2 * WORD_W;
  localparam int SYNC_STAGES = 2;

  localparam logic [MOD_W-1:0] MOD_MEM0  = 2'b00;
  localparam logic [MOD_W-1:0] MOD_MEM8  = 2'b01;
  localparam logic [MOD_W-1:0] MOD_MEM16 = 2'b10;
  localparam logic [MOD_W-1:0] MOD_REG   = 2'b11;
  localparam logic [FLD_W-1:0] RM_DIRECT = 3'b110;

  typedef enum logic [1:0] {
    IMM_NONE   = 2'd0,
    IMM_BYTE_Z = 2'd1,
    IMM_WORD   = 2'd2,
    IMM_BYTE_S = 2'd3
  } imm_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_MODRM   = 3'd1,
    ST_DISP_LO = 3'd2,
    ST_DISP_HI = 3'd3,
    ST_IMM_LO  = 3'd4,
    ST_IMM_HI  = 3'd5,
    ST_DONE    = 3'd6
  } pstate_t;

  typedef struct packed {
    logic [MOD_W-1:0]  mode;
    logic [FLD_W-1:0]  reg_f;
    logic [FLD_W-1:0]  rm;
    logic [WORD_W-1:0] disp;
    logic [WORD_W-1:0] imm;
  } oprec_t;
endpackage

// File: rtl/modrm_rst_sync.sv
module modrm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/modrm_disp_decode.sv
module modrm_disp_decode
  import modrm_pkg::*;
(
  input  logic [BYTE_W-1:0] modrm_byte,
  output logic [1:0]        disp_bytes
);
  logic [MOD_W-1:0] mode;
  logic [FLD_W-1:0] rm;

  assign mode = modrm_byte[BYTE_W-1 -: MOD_W];
  assign rm   = modrm_byte[FLD_W-1:0];

  always_comb begin
    unique case (mode)
      MOD_MEM0:  disp_bytes = (rm == RM_DIRECT) ? 2'd2 : 2'd0;
      MOD_MEM8:  disp_bytes = 2'd1;
      MOD_MEM16: disp_bytes = 2'd2;
      default:   disp_bytes = 2'd0;
    endcase
  end
endmodule

// File: rtl/modrm_seq_ctrl.sv
module modrm_seq_ctrl
  import modrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic       has_modrm,
  input  logic [1:0] imm_kind,
  input  logic       in_valid,
  input  logic [1:0] dec_bytes,
  output logic       op_ready,
  output logic       in_ready,
  output logic       done,
  output logic       ld_cfg,
  output logic       ld_modrm,
  output logic       ld_dlo,
  output logic       ld_dhi,
  output logic       ld_ilo,
  output logic       ld_ihi,
  output logic       imm_sext
);
  pstate_t   state_q, state_d;
  imm_kind_t kind_q, kind_d;
  logic      two_q, two_d;
  logic      take;

  function automatic pstate_t after_disp(imm_kind_t k);
    return (k == IMM_NONE) ? ST_DONE : ST_IMM_LO;
  endfunction

  assign op_ready = (state_q == ST_IDLE);
  assign in_ready = (state_q == ST_MODRM) || (state_q == ST_DISP_LO) ||
                    (state_q == ST_DISP_HI) || (state_q == ST_IMM_LO) ||
                    (state_q == ST_IMM_HI);
  assign done     = (state_q == ST_DONE);
  assign take     = in_valid && in_ready;

  assign ld_cfg   = op_valid && op_ready;
  assign ld_modrm = take && (state_q == ST_MODRM);
  assign ld_dlo   = take && (state_q == ST_DISP_LO);
  assign ld_dhi   = take && (state_q == ST_DISP_HI);
  assign ld_ilo   = take && (state_q == ST_IMM_LO);
  assign ld_ihi   = take && (state_q == ST_IMM_HI);
  assign imm_sext = (kind_q == IMM_BYTE_S);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    two_d   = two_q;
    unique case (state_q)
      ST_IDLE: if (ld_cfg) begin
        kind_d  = imm_kind_t'(imm_kind);
        state_d = has_modrm ? ST_MODRM : after_disp(imm_kind_t'(imm_kind));
      end
      ST_MODRM: if (take) begin
        two_d   = (dec_bytes == 2'd2);
        state_d = (dec_bytes == 2'd0) ? after_disp(kind_q) : ST_DISP_LO;
      end
      ST_DISP_LO: if (take) state_d = two_q ? ST_DISP_HI : after_disp(kind_q);
      ST_DISP_HI: if (take) state_d = after_disp(kind_q);
      ST_IMM_LO:  if (take) state_d = (kind_q == IMM_WORD) ? ST_IMM_HI : ST_DONE;
      ST_IMM_HI:  if (take) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= IMM_NONE;
      two_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld_cfg)   kind_q <= kind_d;
      if (ld_modrm) two_q  <= two_d;
    end
  end
endmodule

// File: rtl/modrm_field_store.sv
module modrm_field_store
  import modrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              ld_cfg,
  input  logic              ld_modrm,
  input  logic              ld_dlo,
  input  logic              ld_dhi,
  input  logic              ld_ilo,
  input  logic              ld_ihi,
  input  logic              imm_sext,
  output oprec_t            rec
);
  oprec_t rec_q, rec_d;
  logic   any_ld;
  logic [BYTE_W-1:0] fill_ext;

  assign any_ld   = ld_cfg | ld_modrm | ld_dlo | ld_dhi | ld_ilo | ld_ihi;
  assign fill_ext = {BYTE_W{in_data[BYTE_W-1]}};

  always_comb begin
    rec_d = rec_q;
    if (ld_cfg) begin
      rec_d = '0;
    end
    if (ld_modrm) begin
      rec_d.mode  = in_data[BYTE_W-1 -: MOD_W];
      rec_d.reg_f = in_data[FLD_W +: FLD_W];
      rec_d.rm    = in_data[FLD_W-1:0];
    end
    if (ld_dlo) begin
      rec_d.disp[BYTE_W-1:0]      = in_data;
      rec_d.disp[WORD_W-1:BYTE_W] = (rec_q.mode == MOD_MEM8) ? fill_ext : '0;
    end
    if (ld_dhi) begin
      rec_d.disp[WORD_W-1:BYTE_W] = in_data;
    end
    if (ld_ilo) begin
      rec_d.imm[BYTE_W-1:0]      = in_data;
      rec_d.imm[WORD_W-1:BYTE_W] = imm_sext ? fill_ext : '0;
    end
    if (ld_ihi) begin
      rec_d.imm[WORD_W-1:BYTE_W] = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (any_ld) rec_q <= rec_d;
  end

  assign rec = rec_q;
endmodule

// File: rtl/modrm_operand_parser.sv
module modrm_operand_parser
  import modrm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              has_modrm,
  input  logic [1:0]        imm_kind,
  output logic              op_ready,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              done,
  output logic [REC_W-1:0]  rec
);
  logic       rst_n_int;
  logic [1:0] dec_bytes;
  logic       ld_cfg, ld_modrm, ld_dlo, ld_dhi, ld_ilo, ld_ihi, imm_sext;
  oprec_t     rec_s;

  modrm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  modrm_disp_decode u_dec (
    .modrm_byte (in_data),
    .disp_bytes (dec_bytes)
  );

  modrm_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .op_valid  (op_valid),
    .has_modrm (has_modrm),
    .imm_kind  (imm_kind),
    .in_valid  (in_valid),
    .dec_bytes (dec_bytes),
    .op_ready  (op_ready),
    .in_ready  (in_ready),
    .done      (done),
    .ld_cfg    (ld_cfg),
    .ld_modrm  (ld_modrm),
    .ld_dlo    (ld_dlo),
    .ld_dhi    (ld_dhi),
    .ld_ilo    (ld_ilo),
    .ld_ihi    (ld_ihi),
    .imm_sext  (imm_sext)
  );

  modrm_field_store u_store (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_data  (in_data),
    .ld_cfg   (ld_cfg),
    .ld_modrm (ld_modrm),
    .ld_dlo   (ld_dlo),
    .ld_dhi   (ld_dhi),
    .ld_ilo   (ld_ilo),
    .ld_ihi   (ld_ihi),
    .imm_sext (imm_sext),
    .rec      (rec_s)
  );

  assign rec = rec_s;
endmodule

// File: rtl/modrm_operand_parser_chk.sv
module modrm_operand_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_ready,
  input logic        in_valid,
  input logic        in_ready,
  input logic        done,
  input logic [39:0] rec
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((in_valid && in_ready) || (op_valid && op_ready)));

  // R11
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> op_ready);

  // R12
  idle_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !in_ready);

  // R7
  regmode_nodisp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rec[39:38] == 2'b11) |-> (rec[31:16] == 16'h0000));

  // R5
  short_disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rec[39:38] == 2'b01) |-> (rec[31:24] == {8{rec[23]}}));

  // R3
  nodisp_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rec[39:38] == 2'b00 && rec[34:32] != 3'b110) |-> (rec[31:16] == 16'h0000));
endmodule

bind modrm_operand_parser modrm_operand_parser_chk u_chk (.*);

// File: tb/sim_modrm_operand_parser.sv
module sim_modrm_operand_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        has_modrm = 1'b0;
  logic [1:0]  imm_kind = 2'd0;
  logic        op_ready;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        done;
  logic [39:0] rec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] pkt [5];

  always #10 clk = ~clk;

  modrm_operand_parser u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int disp_cnt(input logic [7:0] m);
    case (m[7:6])
      2'b00: return (m[2:0] == 3'b110) ? 2 : 0;
      2'b01: return 1;
      2'b10: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int need_bytes(input bit hm, input logic [1:0] k);
    int n = 0;
    if (hm) n = 1 + disp_cnt(pkt[0]);
    if (k == 2'd2) n += 2; else if (k != 2'd0) n += 1;
    return n;
  endfunction

  function automatic logic [39:0] exp_rec(input bit hm, input logic [1:0] k);
    logic [15:0] d = 16'h0, im = 16'h0;
    logic [7:0]  m = 8'h00;
    int idx = 0;
    int nd;
    if (hm) begin
      m = pkt[0];
      idx = 1;
      nd = disp_cnt(m);
      if (nd == 1) d = {{8{pkt[1][7]}}, pkt[1]};
      if (nd == 2) d = {pkt[2], pkt[1]};
      idx += nd;
    end
    case (k)
      2'd1: im = {8'h00, pkt[idx]};
      2'd2: im = {pkt[idx+1], pkt[idx]};
      2'd3: im = {{8{pkt[idx][7]}}, pkt[idx]};
      default: im = 16'h0;
    endcase
    return {m, d, im};
  endfunction

  function automatic string disp_tag(input bit hm);
    if (!hm) return "R10";
    case (pkt[0][7:6])
      2'b00: return (pkt[0][2:0] == 3'b110) ? "R4" : "R3";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_one(input bit hm, input logic [1:0] k, input int gap_pct);
    logic [39:0] e;
    int n, got;
    bit stop;
    n = need_bytes(hm, k);
    e = exp_rec(hm, k);
    got = 0;
    stop = 0;
    @(negedge clk);
    // R12: junk byte offered while idle must be refused and ignored
    in_valid = 1'b1;
    in_data  = 8'hA5;
    chk(in_ready == 1'b0 && op_ready == 1'b1, "R12 idle refuses byte",
        {38'h0, op_ready, in_ready}, 40'h2);
    op_valid  = 1'b1;
    has_modrm = hm;
    imm_kind  = k;
    @(negedge clk);
    op_valid = 1'b0;
    in_valid = 1'b0;
    while (got < n && !stop) begin
      // R11: no early done
      if (done) begin
        chk(1'b0, "R11 done before last byte", {39'h0, done}, 40'h0);
        stop = 1;
      end
      if (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_data  = pkt[got];
        if (!in_ready) begin
          chk(1'b0, "R8 parser refused expected byte", {39'h0, in_ready}, 40'h1);
          stop = 1;
        end else begin
          got++;
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_data  = 8'h5A;
    chk(done == 1'b1 && in_ready == 1'b0, "R11 done after last byte",
        {38'h0, done, in_ready}, 40'h2);
    chk(rec[39:32] == e[39:32], hm ? "R2 modrm fields" : "R10 fields zero",
        {32'h0, rec[39:32]}, {32'h0, e[39:32]});
    chk(rec[31:16] == e[31:16], {disp_tag(hm), " R8 displacement"},
        {24'h0, rec[31:16]}, {24'h0, e[31:16]});
    chk(rec[15:0] == e[15:0], "R9 immediate", {24'h0, rec[15:0]}, {24'h0, e[15:0]});
    @(negedge clk);
    chk(done == 1'b0 && op_ready == 1'b1, "R11 back to idle",
        {38'h0, done, op_ready}, 40'h1);
  endtask

  task automatic set_pkt(input logic [7:0] a, b, c, d, f);
    pkt[0] = a; pkt[1] = b; pkt[2] = c; pkt[3] = d; pkt[4] = f;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(op_ready == 1'b1 && in_ready == 1'b0 && done == 1'b0, "R1 reset state",
        {37'h0, op_ready, in_ready, done}, 40'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corner cases
    set_pkt(8'b00_101_011, 8'h11, 8'h22, 8'h33, 8'h44); run_one(1, 2'd0, 0); // R3
    set_pkt(8'b00_010_110, 8'h34, 8'h12, 8'h9C, 8'h44); run_one(1, 2'd1, 0); // R4
    set_pkt(8'b01_111_000, 8'hF0, 8'h80, 8'h01, 8'h44); run_one(1, 2'd3, 0); // R5
    set_pkt(8'b01_000_110, 8'h7F, 8'hFF, 8'h01, 8'h44); run_one(1, 2'd2, 0); // R5
    set_pkt(8'b10_001_010, 8'hCD, 8'hAB, 8'h78, 8'h56); run_one(1, 2'd2, 0); // R6 R8
    set_pkt(8'b11_110_101, 8'h99, 8'h88, 8'h77, 8'h66); run_one(1, 2'd1, 0); // R7
    set_pkt(8'h80, 8'h00, 8'h00, 8'h00, 8'h00);         run_one(0, 2'd3, 0); // R10 R9
    set_pkt(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);         run_one(0, 2'd0, 0); // R10

    // R13: reset during a parse
    @(negedge clk);
    op_valid = 1'b1; has_modrm = 1'b1; imm_kind = 2'd2;
    @(negedge clk);
    op_valid = 1'b0; in_valid = 1'b1; in_data = 8'b10_000_000;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(op_ready == 1'b1 && in_ready == 1'b0 && done == 1'b0, "R13 reset mid-parse",
        {37'h0, op_ready, in_ready, done}, 40'h4);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    set_pkt(8'b01_011_100, 8'h85, 8'h42, 8'h00, 8'h00); run_one(1, 2'd1, 0); // R13

    // Random mix
    for (int i = 0; i < 400; i++) begin
      for (int j = 0; j < 5; j++) pkt[j] = 8'($urandom);
      if (($urandom % 4) == 0) pkt[0][7:6] = 2'b00;
      if (($urandom % 4) == 0) pkt[0][2:0] = 3'b110;
      run_one(bit'(($urandom % 5) != 0), 2'($urandom), 30);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule